// File: doc/BRIEF.md
# Dual-Channel Disk Interface Interrupt Decoder

This block is the register-level slave of an expansion card that carries two ATA disk channels behind one memory-mapped window. A host performs byte reads and writes on a simple strobe bus. The block decodes these accesses into four things: per-channel interrupt arming, per-channel pending status, a 4-bit card identity, and a select register. The select register opens the channel register region and steers the single shared DMA engine to one of the two channels. The drive taskfiles are not in this block. They appear only as registered chip-select pulses with a register index.

Each channel's interrupt is armed by a write of any value to that channel's arm location. A read from the same location disarms it as a side effect, and the read returns zero. Pending status follows a per-channel drive interrupt level. Software can read it at any time, and reading it does not clear it. The card raises one combined interrupt line. That line is the OR, across channels, of the pending bits whose channel is armed.

Top module: `ata_dual_irq_decoder`

## Requirements
- R1: After synchronous reset, both channel arms are clear, the select register is 0 (so `ext_en` and `dma_sel` are 0), and `irq_out`, `bus_rdata`, `tf_cs`, `ctl_cs` and `tf_idx` are 0.
- R2: While `ext_en` is 1, a write of any byte value to 0x2200 arms channel 0, and a write of any byte value to 0x3200 arms channel 1.
- R3: While `ext_en` is 1, a read from 0x2200 (channel 0) or 0x3200 (channel 1) disarms that channel and returns 0x00.
- R4: While `ext_en` is 1, reads of 0x2290 (channel 0) and 0x3290 (channel 1) return the channel's pending level in bit 0, with bits 7:1 zero. The pending level is `drv_irq[ch]` registered once. The read returns it whether or not the channel is armed, and the read does not clear it.
- R5: `irq_out` equals the OR over both channels of (pending AND armed). It is registered one cycle after those states.
- R6: Reads of 0x2280, 0x2284, 0x2288 and 0x228C return bits 0, 1, 2 and 3 of the card code (default 3) in bit 0, with bits 7:1 zero. These locations are readable whatever the value of `ext_en`.
- R7: The select register sits at 0x0000, and a write stores the whole byte. Bit 5 drives `ext_en` and bit 0 drives `dma_sel` (0 routes DMA to channel 0, 1 routes it to channel 1). A read returns the stored byte, and writing 0 closes the channel register region.
- R8: While `ext_en` is 0, accesses to the channel region 0x2000–0x3FFF (other than the identity bytes) have no effect. Writes do not arm. Reads return 0 and do not disarm. No chip select is raised.
- R9: While `ext_en` is 1, an access (read or write) to the taskfile base plus 64·i (i = 0..7; bases 0x2000 and 0x3000) gives a one-cycle `tf_cs[ch]` pulse with `tf_idx` = i. An access to 0x2380 or 0x3380 gives a one-cycle `ctl_cs[ch]` pulse. At most one select is high, and `tf_idx` is 0 when no taskfile select is active.
- R10: `bus_rdata` is registered. It carries the read value in the cycle after the edge that samples `bus_rd`, and it is 0x00 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (14) | Byte address within the card window |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | DATA_W (8) | Registered read data |
| drv_irq | input | 2 | Per-channel drive interrupt level |
| irq_out | output | 1 | Combined card interrupt |
| dma_sel | output | 1 | Channel that receives the shared DMA signals |
| ext_en | output | 1 | Channel register region open |
| tf_cs | output | 2 | Per-channel taskfile chip-select pulse |
| tf_idx | output | 3 | Taskfile register index for `tf_cs` |
| ctl_cs | output | 2 | Per-channel control/alt-status chip-select pulse |

## Verification
An access sampled at edge N updates the arm, select and pending state at N. `bus_rdata`, `tf_cs`, `tf_idx` and `ctl_cs` become visible after that same edge. `irq_out` follows arming one edge later and follows a change on `drv_irq` two edges later. The reference model applies its updates at each rising edge in exactly that order and compares every output at the falling edge. Directed checks read results 2 ns after the access edge and wait at least two further edges before they judge `irq_out`.

// File: rtl/ata_dual_pkg.sv
package ata_dual_pkg;

  localparam int NCH       = 2;
  localparam int TF_REGS   = 8;
  localparam int TF_IDX_W  = $clog2(TF_REGS);
  localparam int CH_SHIFT  = 12;
  localparam int ID_BITS   = 4;
  localparam int ID_BIT_W  = $clog2(ID_BITS);
  localparam int ID_STEP   = 4;

  localparam logic [31:0] SEL_OFS     = 32'h0000;
  localparam logic [31:0] REGION_BASE = 32'h2000;
  localparam logic [31:0] ID_BASE     = 32'h2280;

  localparam logic [CH_SHIFT-1:0] LOC_ARM  = 12'h200;
  localparam logic [CH_SHIFT-1:0] LOC_STAT = 12'h290;
  localparam logic [CH_SHIFT-1:0] LOC_CTL  = 12'h380;

  typedef struct packed {
    logic                sel_hit;
    logic                id_hit;
    logic [ID_BIT_W-1:0] id_bit;
    logic                ch;
    logic                arm_hit;
    logic                stat_hit;
    logic                ctl_hit;
    logic                tf_hit;
    logic [TF_IDX_W-1:0] tf_idx;
  } dec_t;

endpackage

// File: rtl/ata_dual_addr_dec.sv
module ata_dual_addr_dec
  import ata_dual_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int TF_SHIFT = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  localparam int TF_SPAN = TF_REGS << TF_SHIFT;

  logic [31:0]          a;
  logic [CH_SHIFT-1:0]  loc;
  logic                 in_region;

  always_comb begin
    a         = 32'(addr);
    loc       = a[CH_SHIFT-1:0];
    in_region = (a >> (CH_SHIFT + 1)) == (REGION_BASE >> (CH_SHIFT + 1));
    dec       = '0;
    dec.ch       = a[CH_SHIFT];
    dec.sel_hit  = (a == SEL_OFS);
    for (int k = 0; k < ID_BITS; k++) begin
      if (a == ID_BASE + 32'(k * ID_STEP)) begin
        dec.id_hit = 1'b1;
        dec.id_bit = ID_BIT_W'(k);
      end
    end
    dec.arm_hit  = in_region && (loc == LOC_ARM);
    dec.stat_hit = in_region && (loc == LOC_STAT);
    dec.ctl_hit  = in_region && (loc == LOC_CTL);
    dec.tf_hit   = in_region && (loc < CH_SHIFT'(TF_SPAN)) &&
                   (loc[TF_SHIFT-1:0] == '0);
    dec.tf_idx   = TF_IDX_W'(loc >> TF_SHIFT);
  end

endmodule

// File: rtl/ata_dual_chan.sv
module ata_dual_chan (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic disarm,
  input  logic drv_irq,
  output logic en_q,
  output logic pend_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= drv_irq;
      if (disarm)
        en_q <= 1'b0;
      else if (arm)
        en_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ata_dual_sel_reg.sv
module ata_dual_sel_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sel_q
);

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= '0;
    else if (we)
      sel_q <= wdata;
  end

endmodule

// File: rtl/ata_dual_irq_decoder.sv
module ata_dual_irq_decoder
  import ata_dual_pkg::*;
#(
  parameter int          ADDR_W   = 14,
  parameter int          DATA_W   = 8,
  parameter int          TF_SHIFT = 6,
  parameter int          EXT_BIT  = 5,
  parameter int          DMA_BIT  = 0,
  parameter logic [ID_BITS-1:0] CARD_ID = 4'd3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  input  logic                bus_wr,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NCH-1:0]      drv_irq,
  output logic                irq_out,
  output logic                dma_sel,
  output logic                ext_en,
  output logic [NCH-1:0]      tf_cs,
  output logic [TF_IDX_W-1:0] tf_idx,
  output logic [NCH-1:0]      ctl_cs
);

  dec_t              dec;
  logic [DATA_W-1:0] sel_q;
  logic [NCH-1:0]    en_q;
  logic [NCH-1:0]    pend_q;
  logic [NCH-1:0]    arm;
  logic [NCH-1:0]    disarm;
  logic [DATA_W-1:0] rd_val;
  logic              access;
  logic              open_q;

  assign access = bus_rd | bus_wr;
  assign open_q = sel_q[EXT_BIT];

  ata_dual_addr_dec #(
    .ADDR_W   (ADDR_W),
    .TF_SHIFT (TF_SHIFT)
  ) dec_i (
    .addr (bus_addr),
    .dec  (dec)
  );

  ata_dual_sel_reg #(
    .DATA_W (DATA_W)
  ) sel_i (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_wr && dec.sel_hit),
    .wdata (bus_wdata),
    .sel_q (sel_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign arm[g]    = bus_wr && open_q && dec.arm_hit && (32'(dec.ch) == g);
    assign disarm[g] = bus_rd && open_q && dec.arm_hit && (32'(dec.ch) == g);

    ata_dual_chan chan_i (
      .clk     (clk),
      .rst     (rst),
      .arm     (arm[g]),
      .disarm  (disarm[g]),
      .drv_irq (drv_irq[g]),
      .en_q    (en_q[g]),
      .pend_q  (pend_q[g])
    );
  end

  always_comb begin
    rd_val = '0;
    if (dec.sel_hit)
      rd_val = sel_q;
    else if (dec.id_hit)
      rd_val[0] = CARD_ID[dec.id_bit];
    else if (open_q && dec.stat_hit)
      rd_val[0] = pend_q[dec.ch];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
      tf_cs     <= '0;
      ctl_cs    <= '0;
      tf_idx    <= '0;
    end else begin
      bus_rdata <= bus_rd ? rd_val : '0;
      irq_out   <= |(en_q & pend_q);
      tf_idx    <= (access && open_q && dec.tf_hit) ? dec.tf_idx : '0;
      for (int c = 0; c < NCH; c++) begin
        tf_cs[c]  <= access && open_q && dec.tf_hit  && (32'(dec.ch) == c);
        ctl_cs[c] <= access && open_q && dec.ctl_hit && (32'(dec.ch) == c);
      end
    end
  end

  assign ext_en  = sel_q[EXT_BIT];
  assign dma_sel = sel_q[DMA_BIT];

endmodule

// File: rtl/ata_dual_irq_chk.sv
module ata_dual_irq_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_rdata,
  input logic              irq_out,
  input logic              ext_en,
  input logic              dma_sel,
  input logic [1:0]        tf_cs,
  input logic [1:0]        ctl_cs,
  input logic [1:0]        en_q,
  input logic [1:0]        pend_q
);

  logic rst_d = 1'b0;

  always @(posedge clk) begin
    if (rst_d) begin
      a_reset_state_r1: assert (en_q == 2'b00 && !ext_en && !dma_sel && !irq_out)
        else $error("R1 reset state not clear");
    end
    rst_d <= rst;
  end

  p_arm_ch0_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && ext_en && bus_addr == ADDR_W'(16'h2200)) |=> en_q[0]);

  p_arm_ch1_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && ext_en && bus_addr == ADDR_W'(16'h3200)) |=> en_q[1]);

  p_disarm_ch0_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && ext_en && bus_addr == ADDR_W'(16'h2200)) |=> (!en_q[0] && bus_rdata == 8'h00));

  p_disarm_ch1_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && ext_en && bus_addr == ADDR_W'(16'h3200)) |=> (!en_q[1] && bus_rdata == 8'h00));

  p_irq_source_r5: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past((en_q & pend_q) != 2'b00));

  p_single_select_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tf_cs, ctl_cs}));

  p_closed_no_select_r8: assert property (@(posedge clk) disable iff (rst)
    !ext_en |=> ({tf_cs, ctl_cs} == 4'b0000));

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == 8'h00));

endmodule

bind ata_dual_irq_decoder ata_dual_irq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .ext_en    (ext_en),
  .dma_sel   (dma_sel),
  .tf_cs     (tf_cs),
  .ctl_cs    (ctl_cs),
  .en_q      (en_q),
  .pend_q    (pend_q)
);

// File: tb/ata_dual_irq_decoder_tb_top.sv
`timescale 1ns/1ps
module ata_dual_irq_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic [1:0]  drv_irq = 2'b00;
  logic        irq_out, dma_sel, ext_en;
  logic [1:0]  tf_cs, ctl_cs;
  logic [2:0]  tf_idx;

  always #5 clk = ~clk;

  ata_dual_irq_decoder dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .drv_irq(drv_irq), .irq_out(irq_out), .dma_sel(dma_sel),
    .ext_en(ext_en), .tf_cs(tf_cs), .tf_idx(tf_idx), .ctl_cs(ctl_cs)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  bit started = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_en[2], m_pend[2], m_sel;
  int e_rdata, e_irq, e_tf, e_ctl, e_idx;

  function automatic int region_ch(int a);
    if (a >= 'h3000 && a < 'h4000) return 1;
    if (a >= 'h2000 && a < 'h3000) return 0;
    return -1;
  endfunction

  function automatic int model_read(int a);
    int ch, off;
    if (a == 0) return m_sel;
    if (a == 'h2280) return 3 % 2;
    if (a == 'h2284) return (3 / 2) % 2;
    if (a == 'h2288) return (3 / 4) % 2;
    if (a == 'h228C) return (3 / 8) % 2;
    ch = region_ch(a);
    if (ch < 0 || (m_sel / 32) % 2 == 0) return 0;
    off = a - ('h2000 + ch * 'h1000);
    if (off == 'h290) return m_pend[ch];
    return 0;
  endfunction

  always @(posedge clk) begin
    int a, ch, off, open;
    if (rst) begin
      m_en = '{0, 0}; m_pend = '{0, 0}; m_sel = 0;
      e_rdata = 0; e_irq = 0; e_tf = 0; e_ctl = 0; e_idx = 0;
    end else begin
      a    = int'(bus_addr);
      open = (m_sel / 32) % 2;
      ch   = region_ch(a);
      off  = (ch < 0) ? -1 : a - ('h2000 + ch * 'h1000);
      e_irq   = ((m_en[0] && m_pend[0]) || (m_en[1] && m_pend[1])) ? 1 : 0;
      e_rdata = bus_rd ? model_read(a) : 0;
      e_tf = 0; e_ctl = 0; e_idx = 0;
      if ((bus_rd || bus_wr) && open && ch >= 0) begin
        if (off < 512 && off % 64 == 0) begin
          e_tf = 1 << ch; e_idx = off / 64;
        end
        if (off == 'h380) e_ctl = 1 << ch;
      end
      if (open && ch >= 0 && off == 'h200) begin
        if (bus_wr) m_en[ch] = 1;
        if (bus_rd) m_en[ch] = 0;
      end
      if (bus_wr && a == 0) m_sel = int'(bus_wdata);
      m_pend[0] = int'(drv_irq[0]);
      m_pend[1] = int'(drv_irq[1]);
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R10 rdata vs model", int'(bus_rdata), e_rdata);
      chk("R5 irq_out vs model", int'(irq_out), e_irq);
      chk("R9 tf_cs vs model", int'(tf_cs), e_tf);
      chk("R9 tf_idx vs model", int'(tf_idx), e_idx);
      chk("R9 ctl_cs vs model", int'(ctl_cs), e_ctl);
      chk("R7 ext_en vs model", int'(ext_en), (m_sel / 32) % 2);
      chk("R7 dma_sel vs model", int'(dma_sel), m_sel % 2);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=<50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic [1:0] cap_tf, cap_ctl;
  logic [2:0] cap_idx;

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr_b(int a, int d);
    @(posedge clk); #2;
    bus_addr = 14'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
    cap_tf = tf_cs; cap_ctl = ctl_cs; cap_idx = tf_idx;
  endtask

  task automatic rd_b(int a, output int d);
    @(posedge clk); #2;
    bus_addr = 14'(a); bus_rd = 1'b1;
    @(posedge clk); #2;
    bus_rd = 1'b0;
    d = int'(bus_rdata);
    cap_tf = tf_cs; cap_ctl = ctl_cs; cap_idx = tf_idx;
  endtask

  initial begin
    int d;
    int addrs[12] = '{'h0000, 'h2200, 'h3200, 'h2290, 'h3290, 'h2280,
                      'h228C, 'h2040, 'h3380, 'h2380, 'h31C0, 'h2001};
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    #3;
    // R1 reset state
    chk("R1 irq_out", int'(irq_out), 0);
    chk("R1 ext_en", int'(ext_en), 0);
    chk("R1 dma_sel", int'(dma_sel), 0);
    chk("R1 rdata", int'(bus_rdata), 0);
    chk("R1 selects", int'({tf_cs, ctl_cs, tf_idx}), 0);

    // R6 identity with region closed
    rd_b('h2280, d); chk("R6 id bit0", d, 1);
    rd_b('h2284, d); chk("R6 id bit1", d, 1);
    rd_b('h2288, d); chk("R6 id bit2", d, 0);
    rd_b('h228C, d); chk("R6 id bit3", d, 0);

    // R8 closed region ignores access
    drv_irq = 2'b11;
    wr_b('h2200, 'hFF);
    step(); step(); step();
    chk("R8 closed arm ignored irq", int'(irq_out), 0);
    rd_b('h2290, d); chk("R8 closed status reads 0", d, 0);
    rd_b('h2000, d); chk("R8 closed no tf_cs", int'(cap_tf), 0);

    // R7 open region
    wr_b('h0000, 'h20);
    chk("R7 ext_en set", int'(ext_en), 1);
    chk("R7 dma_sel ch0", int'(dma_sel), 0);
    rd_b('h0000, d); chk("R7 select readback", d, 'h20);

    // R4 pending visible while disarmed
    rd_b('h2290, d); chk("R4 ch0 pending unarmed", d, 1);
    rd_b('h3290, d); chk("R4 ch1 pending unarmed", d, 1);
    chk("R5 no irq unarmed", int'(irq_out), 0);

    // R2 arm channel 0
    drv_irq = 2'b01;
    wr_b('h2200, 'h5A);
    step(); step();
    chk("R2 arm ch0 irq", int'(irq_out), 1);
    rd_b('h2290, d); chk("R4 status read 1", d, 1);
    rd_b('h2290, d); chk("R4 status not cleared", d, 1);
    chk("R4 irq kept after status read", int'(irq_out), 1);

    // R3 disarm by read
    rd_b('h2200, d); chk("R3 arm read data", d, 0);
    step(); step();
    chk("R3 disarm ch0 irq", int'(irq_out), 0);

    // R2/R5 channel 1, value 0 still arms
    wr_b('h3200, 'h00);
    step(); step();
    chk("R5 ch1 armed not pending", int'(irq_out), 0);
    drv_irq = 2'b10;
    step(); step(); step();
    chk("R2 arm ch1 irq", int'(irq_out), 1);
    rd_b('h2280, d); chk("R6 id while open", d, 1);

    // R9 chip selects
    rd_b('h3000 + 5 * 64, d);
    chk("R9 tf_cs ch1", int'(cap_tf), 2);
    chk("R9 tf_idx 5", int'(cap_idx), 5);
    wr_b('h2380, 'h0E);
    chk("R9 ctl_cs ch0", int'(cap_ctl), 1);
    chk("R9 no tf on ctl", int'(cap_tf), 0);
    rd_b('h21C0, d);
    chk("R9 tf_cs ch0 idx7", int'({cap_tf, cap_idx}), {2'b01, 3'd7});
    rd_b('h2001, d);
    chk("R9 misaligned no select", int'({cap_tf, cap_ctl}), 0);

    // R7 DMA steering and closing
    wr_b('h0000, 'h21);
    chk("R7 dma_sel ch1", int'(dma_sel), 1);
    wr_b('h0000, 'h00);
    chk("R7 ext_en cleared", int'(ext_en), 0);
    chk("R7 dma_sel cleared", int'(dma_sel), 0);
    rd_b('h3200, d);
    step(); step();
    chk("R8 closed read no disarm", int'(irq_out), 1);
    rd_b('h3290, d); chk("R8 closed status 0", d, 0);

    wr_b('h0000, 'h20);
    rd_b('h3200, d);
    step(); step();
    chk("R3 disarm ch1 irq", int'(irq_out), 0);
    chk("R10 rdata idle zero", int'(bus_rdata), 0);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #2;
      bus_addr  = 14'(addrs[$urandom_range(0, 11)]);
      bus_wdata = 8'($urandom_range(0, 255));
      if (bus_addr == 14'h0000) bus_wdata[5] = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 2))
        0: begin bus_rd = 1'b1; bus_wr = 1'b0; end
        1: begin bus_rd = 1'b0; bus_wr = 1'b1; end
        default: begin bus_rd = 1'b0; bus_wr = 1'b0; end
      endcase
      if ($urandom_range(0, 7) == 0) drv_irq = 2'($urandom_range(0, 3));
    end
    @(posedge clk); #2;
    bus_rd = 1'b0; bus_wr = 1'b0;
    step(); step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule